// File: doc/BRIEF.md
# Request Legality Guard with Error Responder

This block sits on the device side of a single-beat TileLink-UL style port, between a bus host and a simple register or memory target. It takes one request beat at a time on the request channel and checks it against the protocol's legality rules: the opcode, the byte-count implied by the size field against the enabled byte lanes, the exact lane count for full writes, and the alignment of the address to the size. A legal request is passed to the target as a single-cycle strobe, and the target's read data is captured in the same cycle. An illegal request never reaches the target. The block builds its own response with the error flag set.

Every response, legal or not, leaves through one response slot. It carries the acknowledge opcode that matches the request kind, the request's size and source tag, and a zero param field. While the slot is full, the request channel is not ready, so at most one response is outstanding. The response fields hold still until the host takes them. The data bus is a whole number of bytes, 8 bytes wide at most.

Top module: `req_guard`

## Requirements
- R1: After reset, `d_valid` is low and `a_ready` is high.
- R2: A request opcode other than 4 (read), 0 (full write) or 1 (partial write) is an error. It gets `d_error` = 1 and no target strobe.
- R3: For any opcode, if the number of ones in `a_mask` exceeds 2 to the power `a_size`, the request is an error and does not reach the target.
- R4: For a full write (opcode 0), the number of ones in `a_mask` must equal 2 to the power `a_size` exactly. Otherwise the request is an error and does not reach the target.
- R5: If `a_address` has any bit set below bit position `a_size`, the request is misaligned. It is an error and does not reach the target.
- R6: A legal request raises `t_req` for exactly the accept cycle. In that cycle `t_addr`, `t_wdata` and `t_wmask` equal the request fields, `t_we` is high for opcodes 0 and 1 and low for opcode 4, and the response has `d_error` = 0.
- R7: The response opcode is 1 (ack with data) for a request with opcode 4, and 0 (plain ack) for every other request, including errored ones.
- R8: The response `d_size` and `d_source` equal the request's `a_size` and `a_source`, and `d_param` is always 0.
- R9: For a legal read, `d_data` is the `t_rdata` value present in the accept cycle. For an errored read, `d_data` is all ones. For any write, `d_data` is zero.
- R10: `d_valid` rises on the clock edge that accepts a request. While `d_valid` is high, `a_ready` is low and the response fields are stable. `d_valid` falls on the edge where `d_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_valid | input | 1 | Request beat present |
| a_ready | output | 1 | Block can take a request |
| a_opcode | input | 3 | Request opcode (4 read, 0 full write, 1 partial write) |
| a_size | input | SIZE_W | Log2 of the request byte count |
| a_source | input | SRC_W | Request source tag |
| a_address | input | ADDR_W | Byte address |
| a_mask | input | DATA_W/8 | Byte-lane enables |
| a_data | input | DATA_W | Write data |
| d_valid | output | 1 | Response beat present |
| d_ready | input | 1 | Host takes the response |
| d_opcode | output | 3 | Response opcode (1 ack with data, 0 plain ack) |
| d_param | output | 3 | Always zero |
| d_size | output | SIZE_W | Echo of the request size |
| d_source | output | SRC_W | Echo of the request source |
| d_data | output | DATA_W | Read data, all ones on an errored read |
| d_error | output | 1 | Request was illegal |
| t_req | output | 1 | Target access strobe |
| t_we | output | 1 | Target write enable |
| t_addr | output | ADDR_W | Target address |
| t_wdata | output | DATA_W | Target write data |
| t_wmask | output | DATA_W/8 | Target byte enables |
| t_rdata | input | DATA_W | Target read data, valid in the strobe cycle |

## Verification
The bench builds the block with its defaults: a 32-bit data bus with four byte lanes, a 2-bit size field, an 8-bit source and a 32-bit address. With a 2-bit size field, the size code 3 names eight bytes on a four-lane bus. This lets the bench show that a size larger than the lane count is still legal when the mask and alignment rules hold. The same four lanes let it build masks that are denser than the size allows, holes in partial-write masks, and full writes whose lane count is short. Misaligned addresses at sizes 1 and 2 are also covered, along with a stalled response that sits beside a second waiting request.

// File: rtl/rqg_pkg.sv
package rqg_pkg;

    localparam logic [2:0] REQ_PUT_FULL = 3'd0;
    localparam logic [2:0] REQ_PUT_PART = 3'd1;
    localparam logic [2:0] REQ_GET      = 3'd4;

    localparam logic [2:0] RSP_ACK      = 3'd0;
    localparam logic [2:0] RSP_ACK_DATA = 3'd1;

    // One flag per legality rule; any set flag makes the request an error.
    typedef struct packed {
        logic bad_opcode;
        logic mask_over_size;
        logic full_count_miss;
        logic misaligned;
    } viol_t;

    function automatic logic opcode_known(input logic [2:0] op);
        return (op == REQ_GET) || (op == REQ_PUT_FULL) || (op == REQ_PUT_PART);
    endfunction

    function automatic logic [2:0] rsp_opcode_for(input logic [2:0] op);
        return (op == REQ_GET) ? RSP_ACK_DATA : RSP_ACK;
    endfunction

endpackage

// File: rtl/rqg_check.sv
module rqg_check
    import rqg_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int MASK_W = 4,
    parameter int SIZE_W = 2
) (
    input  logic [2:0]        opcode,
    input  logic [SIZE_W-1:0] size,
    input  logic [ADDR_W-1:0] addr,
    input  logic [MASK_W-1:0] mask,
    output viol_t             viol
);

    int unsigned       lane_cnt;
    int unsigned       span;
    logic [ADDR_W-1:0] low_bits;

    always_comb begin
        lane_cnt = 0;
        for (int i = 0; i < MASK_W; i++) begin
            lane_cnt = lane_cnt + 32'(mask[i]);
        end
        span     = 32'd1 << size;
        low_bits = (ADDR_W'(1) << size) - ADDR_W'(1);

        viol.bad_opcode      = !opcode_known(opcode);
        viol.mask_over_size  = lane_cnt > span;
        viol.full_count_miss = (opcode == REQ_PUT_FULL) && (lane_cnt != span);
        viol.misaligned      = |(addr & low_bits);
    end

endmodule

// File: rtl/rqg_rsp_slot.sv
module rqg_rsp_slot #(
    parameter int SIZE_W = 2,
    parameter int SRC_W  = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              take,
    input  logic [2:0]        in_op,
    input  logic [SIZE_W-1:0] in_size,
    input  logic [SRC_W-1:0]  in_src,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_err,
    output logic              full,
    output logic [2:0]        out_op,
    output logic [SIZE_W-1:0] out_size,
    output logic [SRC_W-1:0]  out_src,
    output logic [DATA_W-1:0] out_data,
    output logic              out_err
);

    always_ff @(posedge clk) begin
        if (rst) begin
            full     <= 1'b0;
            out_op   <= '0;
            out_size <= '0;
            out_src  <= '0;
            out_data <= '0;
            out_err  <= 1'b0;
        end else if (load) begin
            full     <= 1'b1;
            out_op   <= in_op;
            out_size <= in_size;
            out_src  <= in_src;
            out_data <= in_data;
            out_err  <= in_err;
        end else if (take) begin
            full     <= 1'b0;
        end
    end

endmodule

// File: rtl/req_guard.sv
module req_guard
    import rqg_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int SIZE_W = 2,
    parameter int SRC_W  = 8,
    localparam int MASK_W = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              a_valid,
    output logic              a_ready,
    input  logic [2:0]        a_opcode,
    input  logic [SIZE_W-1:0] a_size,
    input  logic [SRC_W-1:0]  a_source,
    input  logic [ADDR_W-1:0] a_address,
    input  logic [MASK_W-1:0] a_mask,
    input  logic [DATA_W-1:0] a_data,
    output logic              d_valid,
    input  logic              d_ready,
    output logic [2:0]        d_opcode,
    output logic [2:0]        d_param,
    output logic [SIZE_W-1:0] d_size,
    output logic [SRC_W-1:0]  d_source,
    output logic [DATA_W-1:0] d_data,
    output logic              d_error,
    output logic              t_req,
    output logic              t_we,
    output logic [ADDR_W-1:0] t_addr,
    output logic [DATA_W-1:0] t_wdata,
    output logic [MASK_W-1:0] t_wmask,
    input  logic [DATA_W-1:0] t_rdata
);

    viol_t             viol;
    logic              illegal;
    logic              accept;
    logic              is_read;
    logic [DATA_W-1:0] rsp_data;

    rqg_check #(
        .ADDR_W (ADDR_W),
        .MASK_W (MASK_W),
        .SIZE_W (SIZE_W)
    ) u_check (
        .opcode (a_opcode),
        .size   (a_size),
        .addr   (a_address),
        .mask   (a_mask),
        .viol   (viol)
    );

    assign illegal = |viol;
    assign a_ready = !d_valid;
    assign accept  = a_valid && a_ready;
    assign is_read = (a_opcode == REQ_GET);

    // Target side: strobe only for legal beats.
    assign t_req   = accept && !illegal;
    assign t_we    = !is_read;
    assign t_addr  = a_address;
    assign t_wdata = a_data;
    assign t_wmask = a_mask;

    always_comb begin
        if (!is_read) begin
            rsp_data = '0;
        end else if (illegal) begin
            rsp_data = '1;
        end else begin
            rsp_data = t_rdata;
        end
    end

    rqg_rsp_slot #(
        .SIZE_W (SIZE_W),
        .SRC_W  (SRC_W),
        .DATA_W (DATA_W)
    ) u_slot (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .take     (d_valid && d_ready),
        .in_op    (rsp_opcode_for(a_opcode)),
        .in_size  (a_size),
        .in_src   (a_source),
        .in_data  (rsp_data),
        .in_err   (illegal),
        .full     (d_valid),
        .out_op   (d_opcode),
        .out_size (d_size),
        .out_src  (d_source),
        .out_data (d_data),
        .out_err  (d_error)
    );

    assign d_param = 3'd0;

endmodule

// File: rtl/rqg_chk.sv
module rqg_chk #(
    parameter int SIZE_W = 2,
    parameter int SRC_W  = 8,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              a_valid,
    input logic              a_ready,
    input logic [2:0]        a_opcode,
    input logic [SIZE_W-1:0] a_size,
    input logic [SRC_W-1:0]  a_source,
    input logic              d_valid,
    input logic              d_ready,
    input logic [2:0]        d_opcode,
    input logic [2:0]        d_param,
    input logic [SIZE_W-1:0] d_size,
    input logic [SRC_W-1:0]  d_source,
    input logic [DATA_W-1:0] d_data,
    input logic              d_error,
    input logic              t_req
);

    // R10
    slot_busy_chk: assert property (@(posedge clk) disable iff (rst)
        d_valid |-> !a_ready);

    // R10
    rsp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        d_valid && !d_ready |=> d_valid && $stable(d_opcode) && $stable(d_size)
            && $stable(d_source) && $stable(d_data) && $stable(d_error));

    // R6
    strobe_on_accept_chk: assert property (@(posedge clk) disable iff (rst)
        t_req |-> a_valid && a_ready);

    // R8
    echo_fields_chk: assert property (@(posedge clk) disable iff (rst)
        a_valid && a_ready |=> d_valid && d_source == $past(a_source)
            && d_size == $past(a_size) && d_param == 3'd0);

    // R7
    read_ack_kind_chk: assert property (@(posedge clk) disable iff (rst)
        a_valid && a_ready && a_opcode == 3'd4 |=> d_opcode == 3'd1);

    // R2
    unknown_op_chk: assert property (@(posedge clk) disable iff (rst)
        a_valid && a_ready && a_opcode != 3'd0 && a_opcode != 3'd1 && a_opcode != 3'd4
            |-> !t_req ##1 d_error);

endmodule

bind req_guard rqg_chk #(
    .SIZE_W (SIZE_W),
    .SRC_W  (SRC_W),
    .DATA_W (DATA_W)
) u_rqg_chk (
    .clk      (clk),
    .rst      (rst),
    .a_valid  (a_valid),
    .a_ready  (a_ready),
    .a_opcode (a_opcode),
    .a_size   (a_size),
    .a_source (a_source),
    .d_valid  (d_valid),
    .d_ready  (d_ready),
    .d_opcode (d_opcode),
    .d_param  (d_param),
    .d_size   (d_size),
    .d_source (d_source),
    .d_data   (d_data),
    .d_error  (d_error),
    .t_req    (t_req)
);

// File: tb/tb_req_guard.sv
`timescale 1ns/1ps
module tb_req_guard;

    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int SIZE_W = 2;
    localparam int SRC_W  = 8;
    localparam int MASK_W = DATA_W / 8;
    localparam int NVEC   = 15;
    localparam logic [31:0] RD_KEY = 32'h5A5A_0000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              a_valid = 1'b0;
    logic              a_ready;
    logic [2:0]        a_opcode = '0;
    logic [SIZE_W-1:0] a_size = '0;
    logic [SRC_W-1:0]  a_source = '0;
    logic [ADDR_W-1:0] a_address = '0;
    logic [MASK_W-1:0] a_mask = '0;
    logic [DATA_W-1:0] a_data = '0;
    logic              d_valid;
    logic              d_ready = 1'b0;
    logic [2:0]        d_opcode;
    logic [2:0]        d_param;
    logic [SIZE_W-1:0] d_size;
    logic [SRC_W-1:0]  d_source;
    logic [DATA_W-1:0] d_data;
    logic              d_error;
    logic              t_req;
    logic              t_we;
    logic [ADDR_W-1:0] t_addr;
    logic [DATA_W-1:0] t_wdata;
    logic [MASK_W-1:0] t_wmask;
    logic [DATA_W-1:0] t_rdata;

    always #2 clk = ~clk;

    // Target model: read data is a fixed function of the address.
    assign t_rdata = t_addr ^ RD_KEY;

    req_guard #(
        .ADDR_W (ADDR_W), .DATA_W (DATA_W), .SIZE_W (SIZE_W), .SRC_W (SRC_W)
    ) dut (.*);

    int checks = 0;
    int errors = 0;
    int strobes = 0;
    logic              last_we;
    logic [ADDR_W-1:0] last_addr;
    logic [DATA_W-1:0] last_wdata;
    logic [MASK_W-1:0] last_wmask;

    always @(posedge clk) begin
        if (t_req) begin
            strobes    <= strobes + 1;
            last_we    <= t_we;
            last_addr  <= t_addr;
            last_wdata <= t_wdata;
            last_wmask <= t_wmask;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R10 watchdog actual=hang expected=done");
        finish_up();
    end

    typedef struct packed {
        logic [2:0]  op;
        logic [1:0]  size;
        logic [31:0] addr;
        logic [3:0]  mask;
        logic        err;
        logic [3:0]  req;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{3'd4, 2'd2, 32'h0000_0100, 4'hF, 1'b0, 4'd6}, // R6 legal read
        '{3'd0, 2'd2, 32'h0000_0104, 4'hF, 1'b0, 4'd6}, // R6 legal full write
        '{3'd1, 2'd2, 32'h0000_0108, 4'h5, 1'b0, 4'd6}, // R6 partial write with lane hole
        '{3'd4, 2'd0, 32'h0000_0103, 4'h8, 1'b0, 4'd6}, // R6 byte read
        '{3'd2, 2'd2, 32'h0000_0000, 4'hF, 1'b1, 4'd2}, // R2 unknown opcode
        '{3'd7, 2'd0, 32'h0000_0000, 4'h1, 1'b1, 4'd2}, // R2 unknown opcode
        '{3'd4, 2'd1, 32'h0000_0020, 4'hF, 1'b1, 4'd3}, // R3 four lanes, size 2 bytes
        '{3'd1, 2'd0, 32'h0000_0020, 4'h3, 1'b1, 4'd3}, // R3 two lanes, size 1 byte
        '{3'd0, 2'd2, 32'h0000_0030, 4'h7, 1'b1, 4'd4}, // R4 full write short
        '{3'd0, 2'd1, 32'h0000_0010, 4'h3, 1'b0, 4'd4}, // R4 full write exact
        '{3'd0, 2'd1, 32'h0000_0010, 4'h1, 1'b1, 4'd4}, // R4 full write one lane
        '{3'd4, 2'd2, 32'h0000_0102, 4'hF, 1'b1, 4'd5}, // R5 misaligned read
        '{3'd1, 2'd1, 32'h0000_0001, 4'h1, 1'b1, 4'd5}, // R5 misaligned write
        '{3'd4, 2'd1, 32'h0000_0002, 4'hC, 1'b0, 4'd5}, // R5 aligned halfword read
        '{3'd4, 2'd3, 32'h0000_0040, 4'hF, 1'b0, 4'd3}  // R3 size above lanes
    };

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(d_valid == 1'b0, "R1 d_valid", 64'(d_valid), 64'd0);
        chk(a_ready == 1'b1, "R1 a_ready", 64'(a_ready), 64'd1);

        for (int i = 0; i < NVEC; i++) begin
            automatic vec_t v = VECS[i];
            automatic int base = strobes;
            automatic logic [31:0] wd = 32'hC0DE_0000 | 32'(i);
            automatic logic [31:0] exp_data;
            automatic string tag = $sformatf("R%0d", v.req);
            if (v.op != 3'd4)  exp_data = '0;
            else if (v.err)    exp_data = '1;
            else               exp_data = v.addr ^ RD_KEY;

            a_opcode  = v.op;
            a_size    = v.size;
            a_address = v.addr;
            a_mask    = v.mask;
            a_data    = wd;
            a_source  = SRC_W'(i + 3);
            a_valid   = 1'b1;
            @(negedge clk);
            a_valid = 1'b0;
            // R10 response present one edge after accept
            chk(d_valid == 1'b1, "R10 d_valid after accept", 64'(d_valid), 64'd1);
            chk(d_error == v.err, {tag, " d_error"}, 64'(d_error), 64'(v.err));
            chk(strobes - base == (v.err ? 0 : 1), {tag, " target strobes"},
                64'(strobes - base), 64'(v.err ? 0 : 1));
            // R7
            chk(d_opcode == ((v.op == 3'd4) ? 3'd1 : 3'd0), "R7 d_opcode",
                64'(d_opcode), 64'((v.op == 3'd4) ? 1 : 0));
            // R8
            chk(d_size == v.size && d_source == SRC_W'(i + 3) && d_param == 3'd0,
                "R8 size/source/param", {d_param, d_size, d_source},
                {3'd0, v.size, 8'(i + 3)});
            // R9
            chk(d_data == exp_data, "R9 d_data", 64'(d_data), 64'(exp_data));
            if (!v.err) begin
                // R6 target fields
                chk(last_we == (v.op != 3'd4) && last_addr == v.addr
                        && last_wdata == wd && last_wmask == v.mask,
                    "R6 target fields", {last_we, last_addr, last_wmask},
                    {(v.op != 3'd4), v.addr, v.mask});
            end
            d_ready = 1'b1;
            @(negedge clk);
            d_ready = 1'b0;
            chk(d_valid == 1'b0 && a_ready == 1'b1, "R10 release", 64'({d_valid, a_ready}),
                64'b01);
        end

        // R10 stall: response held while a second request waits
        begin
            automatic int base = strobes;
            a_opcode = 3'd4; a_size = 2'd2; a_address = 32'h200; a_mask = 4'hF;
            a_source = 8'h51; a_valid = 1'b1;
            @(negedge clk);
            a_source = 8'h52; a_address = 32'h204;
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                chk(a_ready == 1'b0, "R10 not ready while held", 64'(a_ready), 64'd0);
                chk(d_valid && d_source == 8'h51 && d_data == (32'h200 ^ RD_KEY),
                    "R10 held response stable", 64'(d_source), 64'h51);
                chk(strobes - base == 1, "R10 waiting request not taken",
                    64'(strobes - base), 64'd1);
            end
            d_ready = 1'b1;
            @(negedge clk);
            d_ready = 1'b0;
            chk(d_valid == 1'b0, "R10 consumed", 64'(d_valid), 64'd0);
            @(negedge clk);
            a_valid = 1'b0;
            chk(d_valid && d_source == 8'h52 && d_data == (32'h204 ^ RD_KEY),
                "R10 second request answered", 64'(d_source), 64'h52);
            chk(strobes - base == 2, "R6 second strobe", 64'(strobes - base), 64'd2);
            d_ready = 1'b1;
            @(negedge clk);
            d_ready = 1'b0;
        end

        // R1 reset clears a held response
        a_opcode = 3'd0; a_size = 2'd2; a_mask = 4'hF; a_address = 32'h0; a_valid = 1'b1;
        @(negedge clk);
        a_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(d_valid == 1'b0 && a_ready == 1'b1, "R1 reset clears slot",
            64'({d_valid, a_ready}), 64'b01);

        finish_up();
    end

endmodule